// File: doc/BRIEF.md
# Saturating Usage Log Accumulator

This block gathers run-time statistics that are later written back to a small nonvolatile record. It has a set of pending error counters, each bumped by an increment pulse that carries an amount. It also has an active-time counter that counts seconds and turns every full hour into one pending hour. A copy of the record image is kept in a register array. Before a flush, the image is loaded through a byte write port. After a flush, it is read back through a combinational byte read port.

A flush request goes through a valid/ready handshake. The block then merges the pending values into the image with saturating arithmetic, keeping any leftover seconds. It tracks the highest byte offset whose stored value actually changed. If anything changed, it rewrites the checksum byte. It then returns one result item: a write-back flag and a prefix length covering every changed byte. A separate writer copies that prefix to the nonvolatile store.

The result item is held on the output until the consumer takes it. `res_valid` stays high and `res_wb` and `res_len` stay stable while `res_ready` is low. A new flush is accepted only when the block is idle, so the consumer's back-pressure stalls the requester as well. Increment pulses and seconds ticks are accepted in every cycle, including during a flush.

Top module: `usage_log_acc`

## Requirements
- R1: Each pending counter i adds `inc_amt[8i+7:8i]` when `inc_en[i]` is high, and saturates at 255.
- R2: On a flush, each counter whose pending value is nonzero updates its image byte at offset 2+i. The new value is min(stored + pending, 255). All pending counts are cleared.
- R3: A flush with all pending counts at zero and no whole pending hour leaves the image unchanged. It returns `res_wb`=0 and `res_len`=0.
- R4: Every 3600 `sec_tick` pulses make one pending hour, and the remaining seconds are kept. A flush adds the pending hours to the 16-bit hour count stored little-endian (low byte at offset 6, high byte at offset 7), clamps the sum at 0xFFFF, and clears the pending hours.
- R5: The result reports the highest offset H whose stored byte value changed. Then `res_wb`=1 and `res_len`=H+1. A merge that leaves a byte at its old value, for example on a saturated counter, does not count as a change.
- R6: When `res_wb`=1, offset 1 holds the bitwise inverse of the 8-bit sum of the bytes at offsets below L, with offset 1 excluded. L is the value at offset 0, limited to 16. When `res_wb`=0, offset 1 is not rewritten.
- R7: Increment pulses and ticks that arrive while a flush is in progress are kept. The next flush merges them.
- R8: `flush_ready` is high only when the block is idle. A held result keeps `res_wb` and `res_len` stable until `res_ready`. Image writes through `img_we` are ignored while a flush is in progress.
- R9: After reset, all pending state and image bytes are zero, `flush_ready`=1 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_en | input | 4 | Per-counter increment strobe |
| inc_amt | input | 32 | Per-counter increment amounts, 8 bits each |
| sec_tick | input | 1 | One-second active-time pulse |
| flush_valid | input | 1 | Flush request valid |
| flush_ready | output | 1 | Flush request accepted when high (idle) |
| res_valid | output | 1 | Result item valid |
| res_ready | input | 1 | Result consumer ready |
| res_wb | output | 1 | Write-back needed |
| res_len | output | 5 | Prefix length to write back (0 when none) |
| img_we | input | 1 | Image byte write enable (idle only) |
| img_waddr | input | 4 | Image write offset |
| img_wdata | input | 8 | Image write data |
| img_raddr | input | 4 | Image read offset |
| img_rdata | output | 8 | Image read data (combinational) |

## Verification
The bench targets saturation in three places: a pending counter pushed past 255, a merge that meets an already-full stored byte, and an hour count clamped at 0xFFFF. A design that wraps instead of clamping would return small values there. A design that counts a write as a change even when the value stays the same would ask for a write-back that is not needed. The bench also flushes one tick short of a full hour and then one tick after it. This checks that leftover seconds survive a flush: a design that drops them would lose an hour. It also uses length fields above and below the record size, which catches a checksum that sums the wrong span or includes its own byte. Finally, it holds the result under back-pressure and sends increments and an image write during a busy flush. A design that dropped those pulses, or accepted the write, would show it in the next result or in the image read-back.

// File: rtl/ula_pkg.sv
package ula_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE,
    ST_SUM,
    ST_CSUM,
    ST_RESP
  } ula_state_t;

  // Record layout: offsets the write-back prefix logic depends on
  localparam int LEN_OFF  = 0;
  localparam int CSUM_OFF = 1;
  localparam int ERR_OFF  = 2;

  function automatic logic [7:0] sat_add8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction
endpackage

// File: rtl/ula_pend_ctr.sv
module ula_pend_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic [W-1:0] inc_amt,
  input  logic         clear,
  output logic [W-1:0] count
);
  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = clear ? '0 : count;
    sum  = {1'b0, base} + {1'b0, (inc_en ? inc_amt : {W{1'b0}})};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc_en || clear) begin
      count <= sum[W] ? {W{1'b1}} : sum[W-1:0];
    end
  end
endmodule

// File: rtl/ula_time_acc.sv
module ula_time_acc #(
  parameter int SEC_PER_HR = 3600,
  parameter int HRS_W      = 16,
  localparam int FW        = $clog2(SEC_PER_HR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  output logic [FW-1:0]    frac,
  output logic [HRS_W-1:0] hours
);
  logic             roll;
  logic [HRS_W-1:0] hbase;
  logic [HRS_W:0]   hsum;

  always_comb begin
    roll  = tick && (frac == FW'(SEC_PER_HR - 1));
    hbase = clear ? '0 : hours;
    hsum  = {1'b0, hbase} + {{HRS_W{1'b0}}, roll};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac  <= '0;
      hours <= '0;
    end else begin
      if (tick) frac <= roll ? '0 : frac + FW'(1);
      hours <= hsum[HRS_W] ? {HRS_W{1'b1}} : hsum[HRS_W-1:0];
    end
  end
endmodule

// File: rtl/ula_sum_walk.sv
module ula_sum_walk #(
  parameter int RB     = 16,
  parameter int CK_OFF = 1,
  localparam int AW    = $clog2(RB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   len_lim,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] idx,
  output logic          last,
  output logic [7:0]    acc
);
  logic busy;

  assign last = busy && (idx == AW'(RB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      acc  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      acc  <= '0;
    end else if (busy) begin
      if (({1'b0, idx} < len_lim) && (idx != AW'(CK_OFF))) acc <= acc + byte_in;
      idx <= idx + AW'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/usage_log_acc.sv
module usage_log_acc #(
  parameter int NUM_CNT    = 4,
  parameter int REC_BYTES  = 16,
  parameter int SEC_PER_HR = 3600,
  localparam int AW        = $clog2(REC_BYTES),
  localparam int LEN_W     = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CNT-1:0]   inc_en,
  input  logic [NUM_CNT*8-1:0] inc_amt,
  input  logic                 sec_tick,
  input  logic                 flush_valid,
  output logic                 flush_ready,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_wb,
  output logic [LEN_W-1:0]     res_len,
  input  logic                 img_we,
  input  logic [AW-1:0]        img_waddr,
  input  logic [7:0]           img_wdata,
  input  logic [AW-1:0]        img_raddr,
  output logic [7:0]           img_rdata
);
  import ula_pkg::*;

  localparam int HRS_OFF = ERR_OFF + NUM_CNT;
  localparam int FW      = $clog2(SEC_PER_HR);

  ula_state_t state;
  logic [7:0] rec [REC_BYTES];

  // pending counters
  logic [7:0]             pend [NUM_CNT];
  logic [NUM_CNT*8-1:0]   pend_flat;
  logic                   pend_clr;
  logic [FW-1:0]          time_frac;
  logic [15:0]            hrs_pend;

  assign pend_clr = (state == ST_MERGE);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ula_pend_ctr #(.W(8)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_en (inc_en[g]),
      .inc_amt(inc_amt[g*8 +: 8]),
      .clear  (pend_clr),
      .count  (pend[g])
    );
    assign pend_flat[g*8 +: 8] = pend[g];
  end

  ula_time_acc #(.SEC_PER_HR(SEC_PER_HR), .HRS_W(16)) u_time (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sec_tick),
    .clear(pend_clr),
    .frac (time_frac),
    .hours(hrs_pend)
  );

  // merge computation
  logic [7:0]   err_new [NUM_CNT];
  logic [NUM_CNT-1:0] err_chg;
  logic [16:0]  hsum;
  logic [15:0]  hnew;
  logic         hlo_chg, hhi_chg;
  logic [AW-1:0] mark_nx, mark;
  logic         any_work;

  always_comb begin
    mark_nx  = '0;
    any_work = (hrs_pend != 16'd0);
    for (int i = 0; i < NUM_CNT; i++) begin
      err_new[i] = sat_add8(rec[ERR_OFF + i], pend[i]);
      err_chg[i] = (pend[i] != 8'd0) && (err_new[i] != rec[ERR_OFF + i]);
      if (pend[i] != 8'd0) any_work = 1'b1;
      if (err_chg[i]) mark_nx = AW'(ERR_OFF + i);
    end
    hsum    = {1'b0, rec[HRS_OFF + 1], rec[HRS_OFF]} + {1'b0, hrs_pend};
    hnew    = hsum[16] ? 16'hFFFF : hsum[15:0];
    hlo_chg = (hrs_pend != 16'd0) && (hnew[7:0] != rec[HRS_OFF]);
    hhi_chg = (hrs_pend != 16'd0) && (hnew[15:8] != rec[HRS_OFF + 1]);
    if (hlo_chg) mark_nx = AW'(HRS_OFF);
    if (hhi_chg) mark_nx = AW'(HRS_OFF + 1);
  end

  // checksum walk
  logic [LEN_W-1:0] len_lim;
  logic [AW-1:0]    walk_idx;
  logic             walk_last, walk_start;
  logic [7:0]       walk_acc;

  assign len_lim    = (rec[LEN_OFF] > 8'(REC_BYTES)) ? LEN_W'(REC_BYTES) : LEN_W'(rec[LEN_OFF]);
  assign walk_start = (state == ST_MERGE) && (mark_nx != '0);

  ula_sum_walk #(.RB(REC_BYTES), .CK_OFF(CSUM_OFF)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (walk_start),
    .len_lim(len_lim),
    .byte_in(rec[walk_idx]),
    .idx    (walk_idx),
    .last   (walk_last),
    .acc    (walk_acc)
  );

  // control
  assign flush_ready = (state == ST_IDLE);
  assign img_rdata   = rec[img_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mark      <= '0;
      res_valid <= 1'b0;
      res_wb    <= 1'b0;
      res_len   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (flush_valid) begin
            if (any_work) begin
              state <= ST_MERGE;
            end else begin
              state     <= ST_RESP;
              res_valid <= 1'b1;
              res_wb    <= 1'b0;
              res_len   <= '0;
            end
          end
        end
        ST_MERGE: begin
          mark <= mark_nx;
          if (mark_nx != '0) begin
            state <= ST_SUM;
          end else begin
            state     <= ST_RESP;
            res_valid <= 1'b1;
            res_wb    <= 1'b0;
            res_len   <= '0;
          end
        end
        ST_SUM: begin
          if (walk_last) state <= ST_CSUM;
        end
        ST_CSUM: begin
          state     <= ST_RESP;
          res_valid <= 1'b1;
          res_wb    <= 1'b1;
          res_len   <= {1'b0, mark} + LEN_W'(1);
        end
        ST_RESP: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // record image
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < REC_BYTES; k++) rec[k] <= 8'd0;
    end else begin
      if (state == ST_IDLE && img_we) rec[img_waddr] <= img_wdata;
      if (state == ST_MERGE) begin
        for (int i = 0; i < NUM_CNT; i++)
          if (err_chg[i]) rec[ERR_OFF + i] <= err_new[i];
        if (hlo_chg) rec[HRS_OFF]     <= hnew[7:0];
        if (hhi_chg) rec[HRS_OFF + 1] <= hnew[15:8];
      end
      if (state == ST_CSUM) rec[CSUM_OFF] <= ~walk_acc;
    end
  end
endmodule

// File: rtl/usage_log_acc_chk.sv
module usage_log_acc_chk #(
  parameter int NUM_CNT    = 4,
  parameter int SEC_PER_HR = 3600,
  parameter int LEN_W      = 5,
  parameter int FW         = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush_ready,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_wb,
  input logic [LEN_W-1:0]     res_len,
  input logic [NUM_CNT*8-1:0] pend_flat,
  input logic                 pend_clr,
  input logic [FW-1:0]        time_frac
);
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_wb) && $stable(res_len));

  p_busy_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !flush_ready);

  p_len_matches_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_wb == (res_len != '0)));

  p_frac_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    time_frac < FW'(SEC_PER_HR));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_sat
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_flat[g*8 +: 8]) == 8'hFF) && !$past(pend_clr) |-> pend_flat[g*8 +: 8] == 8'hFF);
  end
endmodule

bind usage_log_acc usage_log_acc_chk #(
  .NUM_CNT(NUM_CNT), .SEC_PER_HR(SEC_PER_HR), .LEN_W(LEN_W), .FW($clog2(SEC_PER_HR))
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_ready(flush_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_wb(res_wb), .res_len(res_len),
  .pend_flat(pend_flat), .pend_clr(pend_clr), .time_frac(time_frac)
);

// File: tb/usage_log_acc_tb.sv
module usage_log_acc_tb;
  localparam int NC = 4, RB = 16, SPH = 3600;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0] inc_en = '0;
  logic [NC*8-1:0] inc_amt = '0;
  logic sec_tick = 0, flush_valid = 0, flush_ready;
  logic res_valid, res_ready = 1, res_wb;
  logic [4:0] res_len;
  logic img_we = 0;
  logic [3:0] img_waddr = '0, img_raddr = '0;
  logic [7:0] img_wdata = '0, img_rdata;

  always #2.5 clk = ~clk;

  usage_log_acc u_dut (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .inc_amt(inc_amt), .sec_tick(sec_tick),
    .flush_valid(flush_valid), .flush_ready(flush_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_wb(res_wb), .res_len(res_len), .img_we(img_we),
    .img_waddr(img_waddr), .img_wdata(img_wdata), .img_raddr(img_raddr), .img_rdata(img_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int img [RB];
  int pend [NC];
  int secs = 0;

  typedef struct { bit wb; int len; string req; } exp_t;
  exp_t q [$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected items as results are taken
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q.size() == 0) chk("R8 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({e.req, " wb"}, int'(res_wb), int'(e.wb));
        chk({e.req, " len"}, int'(res_len), e.len);
      end
    end
  end

  task automatic wr_img(int a, int d);
    @(negedge clk);
    img_we = 1; img_waddr = 4'(a); img_wdata = 8'(d);
    @(negedge clk);
    img_we = 0;
    img[a] = d;
  endtask

  task automatic inc(int c, int amt);
    @(negedge clk);
    inc_en[c] = 1; inc_amt[c*8 +: 8] = 8'(amt);
    @(negedge clk);
    inc_en[c] = 0;
    pend[c] = (pend[c] + amt > 255) ? 255 : pend[c] + amt;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    sec_tick = 1;
    repeat (n) @(negedge clk);
    sec_tick = 0;
    secs += n;
  endtask

  function automatic exp_t model_flush(string req);
    exp_t e; int ch = 0; int h; int hrs; int nv; int s; int l;
    for (int i = 0; i < NC; i++) begin
      if (pend[i] != 0) begin
        nv = img[2+i] + pend[i]; if (nv > 255) nv = 255;
        if (nv != img[2+i]) begin img[2+i] = nv; ch = 2 + i; end
        pend[i] = 0;
      end
    end
    hrs = secs / SPH;
    if (hrs > 0) begin
      secs -= hrs * SPH;
      h = img[6] + img[7] * 256 + hrs; if (h > 65535) h = 65535;
      if ((h & 255) != img[6]) begin img[6] = h & 255; ch = 6; end
      if ((h >> 8) != img[7]) begin img[7] = h >> 8; ch = 7; end
    end
    if (ch != 0) begin
      l = (img[0] > RB) ? RB : img[0];
      s = 0;
      for (int k = 0; k < l; k++) if (k != 1) s += img[k];
      img[1] = (~s) & 255;
    end
    e.wb = (ch != 0); e.len = (ch != 0) ? ch + 1 : 0; e.req = req;
    return e;
  endfunction

  task automatic start_flush(string req);
    @(negedge clk);
    while (!flush_ready) @(negedge clk);
    flush_valid = 1;
    q.push_back(model_flush(req));
    @(negedge clk);
    flush_valid = 0;
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic flush(string req);
    start_flush(req);
    wait_drain();
  endtask

  task automatic cmp_img(string req);
    for (int k = 0; k < RB; k++) begin
      @(negedge clk);
      img_raddr = 4'(k);
      #1;
      chk(k == 1 ? "R6 checksum byte" : req, int'(img_rdata), img[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < RB; k++) img[k] = 0;
    for (int i = 0; i < NC; i++) pend[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 flush_ready", int'(flush_ready), 1);
    chk("R9 res_valid", int'(res_valid), 0);
    cmp_img("R9 image zero");

    // preload image
    wr_img(0, 8); wr_img(2, 10); wr_img(3, 250); wr_img(4, 255); wr_img(5, 0);
    wr_img(6, 8'h34); wr_img(7, 8'h12); wr_img(1, 8'h5A);

    // R3 nothing pending
    flush("R3 idle flush");
    cmp_img("R3 image unchanged");

    // R1 saturation in pending, R2 merge
    inc(0, 200); inc(0, 100); inc(1, 3); inc(3, 1); inc(3, 2);
    flush("R2 merge");
    cmp_img("R2 merged image");

    // R5 saturated stored byte: no change
    inc(2, 5);
    flush("R5 no-change merge");
    cmp_img("R5 image");

    // R1 pending wrap check: 255 pending on full byte stays
    inc(1, 255); inc(1, 255);
    flush("R1 pending saturate");
    cmp_img("R1 image");

    // R4 hours with remainder
    ticks(2 * SPH + 100);
    flush("R4 two hours");
    cmp_img("R4 hours image");
    ticks(SPH - 101);
    flush("R4 one tick short");
    ticks(1);
    flush("R4 remainder completes hour");
    cmp_img("R4 remainder image");

    // R4 clamp
    wr_img(6, 8'hFE); wr_img(7, 8'hFF);
    ticks(2 * SPH);
    flush("R4 clamp");
    ticks(SPH);
    flush("R4 clamped no change");
    cmp_img("R4 clamp image");

    // R6 length field beyond record size and short
    wr_img(0, 40); wr_img(12, 8'h40); wr_img(3, 0);
    inc(1, 1);
    flush("R6 long length");
    cmp_img("R6 long image");
    wr_img(0, 3); wr_img(2, 7);
    inc(0, 1);
    flush("R6 short length");
    cmp_img("R6 short image");

    // R7 increments during flush, R8 write ignored while busy, backpressure
    res_ready = 0;
    inc(3, 1);
    start_flush("R7 first flush");
    inc_en[1] = 1; inc_amt[8 +: 8] = 8'd7;
    @(negedge clk);
    inc_en[1] = 0;
    img_we = 1; img_waddr = 4'd10; img_wdata = 8'h77;
    @(negedge clk);
    img_we = 0;
    while (!res_valid) @(negedge clk);
    begin
      int w0, l0;
      w0 = int'(res_wb); l0 = int'(res_len);
      repeat (5) @(negedge clk);
      chk("R8 held valid", int'(res_valid), 1);
      chk("R8 held len", int'(res_len), l0);
      chk("R8 held wb", int'(res_wb), w0);
      chk("R8 ready low while held", int'(flush_ready), 0);
    end
    res_ready = 1;
    wait_drain();
    pend[1] = 7;
    chk("R8 image write ignored", img[10], 0);
    cmp_img("R8 image after busy write");
    flush("R7 kept increments");
    cmp_img("R7 image");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule